// File: doc/BRIEF.md
# Dual-Chamber Tracking Pacing Sequencer

This block sequences atrial and ventricular pacing for a dual-chamber pacemaker that senses both chambers and tracks atrial activity. It advances only on a 1 ms timing strobe. On each strobe it samples the atrial and ventricular sense inputs. It steps through four phases in a fixed loop. The ventricular escape phase is used only after reset. After that the loop runs upper-rate hold, then atrial escape, then AV delay, then back to the hold. Each chamber's pace is issued only when its escape window runs out with no sense in that chamber.

Three programmable interval inputs give the window lengths in ticks: the lower-rate interval, the upper-rate interval and the AV delay. The atrial escape window is derived from them as lower-rate interval minus AV delay minus upper-rate interval. Each chamber has its own sensing-enable flag. The enables open and close as the phase changes, and a sense on a closed channel is dropped. The current phase is visible on a 2-bit status output.

Top module: `dcp_sequencer`

## Requirements
- R1: After reset the phase output is 0 (ventricular escape), ventricular sensing is enabled, atrial sensing is disabled and neither pace output is high.
- R2: In phase 0, if no enabled ventricular sense arrives, a ventricular pace is issued on the tick that completes the lower-rate window (the LRI-th tick counted in the phase). An enabled ventricular sense before that tick ends the phase without a pace.
- R3: Any ventricular event, sensed or paced, moves the sequencer to phase 1 (upper-rate hold) with both sensing enables low. The hold lasts URI ticks, during which no pace is issued.
- R4: At the end of the hold the phase becomes 2 (atrial escape). Only atrial sensing is enabled.
- R5: The atrial escape window lasts LRI-AVD-URI ticks. If no atrial sense arrives, an atrial pace is issued on its last tick. When LRI-AVD-URI is zero or negative, the window is one tick.
- R6: An enabled atrial sense during phase 2 ends the window on that tick with no atrial pace.
- R7: Any atrial event, sensed or paced, moves the sequencer to phase 3 (AV delay) with atrial sensing disabled and ventricular sensing enabled.
- R8: In phase 3 an enabled ventricular sense within AVD ticks inhibits the ventricular pace. Otherwise a ventricular pace is issued on the AVD-th tick. Either way the sequencer then returns to phase 1.
- R9: A sense that arrives on the same tick as a window expiry counts as a sense, so no pace is issued on that tick.
- R10: A sense has no effect on phase, enables or paces if its channel is disabled or if it is not accompanied by a tick. Phase changes happen only on ticks.
- R11: A pace output is high for exactly one clock cycle, in the cycle after the tick that caused it. The two pace outputs are never high together.
- R12: A window's length is taken from the interval inputs on the first tick of its phase. A programmed value of zero for LRI, URI or AVD acts as one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 1 ms timing strobe |
| a_sense_i | input | 1 | Atrial sense, sampled only with tick_i |
| v_sense_i | input | 1 | Ventricular sense, sampled only with tick_i |
| lri_i | input | TW | Lower-rate interval in ticks |
| uri_i | input | TW | Upper-rate interval in ticks |
| avd_i | input | TW | AV delay in ticks |
| a_pace_o | output | 1 | Atrial pace strobe |
| v_pace_o | output | 1 | Ventricular pace strobe |
| a_sense_en_o | output | 1 | Atrial sensing enabled |
| v_sense_en_o | output | 1 | Ventricular sensing enabled |
| phase_o | output | 2 | 0 ventricular escape, 1 upper-rate hold, 2 atrial escape, 3 AV delay |

## Verification
The properties assume nothing about the interval inputs: they may change at any cycle and take any value, including zero and combinations where the atrial window goes negative. The properties do assume that tick_i is a single-cycle strobe, so a tick-free cycle cannot move the phase. The stimulus separates ticks by at least one idle cycle. During those idle cycles it drives random sense levels. It re-draws the interval values at random during a run, including mid-window, so the first-tick sampling rule is exercised.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

   typedef enum logic [1:0] {
      PH_VESC = 2'd0,
      PH_HOLD = 2'd1,
      PH_AESC = 2'd2,
      PH_AVD  = 2'd3
   } dcp_phase_e;

   typedef struct packed {
      logic a_en;
      logic v_en;
   } dcp_sense_en_t;

   // Enables that take effect when a phase is entered.
   function automatic dcp_sense_en_t entry_enables(dcp_phase_e ph);
      dcp_sense_en_t e;
      case (ph)
         PH_HOLD: e = '{a_en: 1'b0, v_en: 1'b0};
         PH_AESC: e = '{a_en: 1'b1, v_en: 1'b0};
         default: e = '{a_en: 1'b0, v_en: 1'b1};
      endcase
      return e;
   endfunction

endpackage

// File: rtl/dcp_window_sel.sv
module dcp_window_sel
   import dcp_pkg::*;
#(
   parameter int TW = 12
) (
   input  dcp_phase_e      phase_i,
   input  logic [TW-1:0]   lri_i,
   input  logic [TW-1:0]   uri_i,
   input  logic [TW-1:0]   avd_i,
   output logic [TW-1:0]   len_o
);
   localparam int          SW  = TW + 2;
   localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

   logic signed [SW-1:0] esc_s;
   logic [TW-1:0]        lri_c, uri_c, avd_c;

   // Zero-valued programmed intervals act as a single tick.
   always_comb begin
      lri_c = (lri_i == '0) ? ONE : lri_i;
      uri_c = (uri_i == '0) ? ONE : uri_i;
      avd_c = (avd_i == '0) ? ONE : avd_i;
   end

   // Atrial escape length uses the raw programmed values, widened to signed.
   always_comb begin
      esc_s = $signed({2'b00, lri_i}) - $signed({2'b00, avd_i})
            - $signed({2'b00, uri_i});
   end

   always_comb begin
      case (phase_i)
         PH_VESC: len_o = lri_c;
         PH_HOLD: len_o = uri_c;
         PH_AESC: len_o = (esc_s <= 0) ? ONE : esc_s[TW-1:0];
         default: len_o = avd_c;
      endcase
   end

endmodule

// File: rtl/dcp_interval_timer.sv
module dcp_interval_timer #(
   parameter int TW         = 12,
   parameter bit DOWN_COUNT = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          restart_i,
   input  logic [TW-1:0] len_i,
   output logic          last_o
);
   localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

   // Set on phase entry; the window length is captured on the next tick.
   logic fresh_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)        fresh_q <= 1'b1;
      else if (restart_i) fresh_q <= 1'b1;
      else if (tick_i)    fresh_q <= 1'b0;
   end

   generate
      if (DOWN_COUNT) begin : g_down
         logic [TW-1:0] rem_q;

         assign last_o = tick_i && (fresh_q ? (len_i <= ONE) : (rem_q <= ONE));

         always_ff @(posedge clk_i) begin
            if (!rst_ni)
               rem_q <= '0;
            else if (tick_i && !restart_i)
               rem_q <= fresh_q ? (len_i - ONE) : (rem_q - ONE);
         end
      end else begin : g_up
         logic [TW-1:0] cnt_q;
         logic [TW-1:0] lim_q;

         assign last_o = tick_i && (fresh_q ? (len_i <= ONE) : ((cnt_q + ONE) >= lim_q));

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               cnt_q <= '0;
               lim_q <= '0;
            end else if (tick_i && !restart_i) begin
               if (fresh_q) begin
                  lim_q <= len_i;
                  cnt_q <= ONE;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dcp_phase_ctrl.sv
module dcp_phase_ctrl
   import dcp_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       a_sense_i,
   input  logic       v_sense_i,
   input  logic       last_i,
   output dcp_phase_e phase_o,
   output logic       a_en_o,
   output logic       v_en_o,
   output logic       a_pace_o,
   output logic       v_pace_o,
   output logic       restart_o
);
   dcp_phase_e    phase_q, phase_d;
   dcp_sense_en_t en_q, en_entry;
   logic          a_hit, v_hit;
   logic          fire_a, fire_v;
   logic          a_pace_q, v_pace_q;

   // Only enabled channels on a tick count as events.
   assign a_hit = tick_i && a_sense_i && en_q.a_en;
   assign v_hit = tick_i && v_sense_i && en_q.v_en;

   always_comb begin
      phase_d = phase_q;
      fire_a  = 1'b0;
      fire_v  = 1'b0;
      case (phase_q)
         PH_VESC: begin
            if (v_hit)       phase_d = PH_HOLD;
            else if (last_i) begin phase_d = PH_HOLD; fire_v = 1'b1; end
         end
         PH_HOLD: begin
            if (last_i)      phase_d = PH_AESC;
         end
         PH_AESC: begin
            if (a_hit)       phase_d = PH_AVD;
            else if (last_i) begin phase_d = PH_AVD; fire_a = 1'b1; end
         end
         default: begin
            if (v_hit)       phase_d = PH_HOLD;
            else if (last_i) begin phase_d = PH_HOLD; fire_v = 1'b1; end
         end
      endcase
   end

   assign restart_o = (phase_d != phase_q);
   assign en_entry  = entry_enables(phase_d);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q  <= PH_VESC;
         en_q     <= '{a_en: 1'b0, v_en: 1'b1};
         a_pace_q <= 1'b0;
         v_pace_q <= 1'b0;
      end else begin
         phase_q  <= phase_d;
         a_pace_q <= fire_a;
         v_pace_q <= fire_v;
         if (restart_o) en_q <= en_entry;
      end
   end

   assign phase_o  = phase_q;
   assign a_en_o   = en_q.a_en;
   assign v_en_o   = en_q.v_en;
   assign a_pace_o = a_pace_q;
   assign v_pace_o = v_pace_q;

endmodule

// File: rtl/dcp_sequencer.sv
module dcp_sequencer
   import dcp_pkg::*;
#(
   parameter int TW         = 12,
   parameter bit DOWN_COUNT = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          a_sense_i,
   input  logic          v_sense_i,
   input  logic [TW-1:0] lri_i,
   input  logic [TW-1:0] uri_i,
   input  logic [TW-1:0] avd_i,
   output logic          a_pace_o,
   output logic          v_pace_o,
   output logic          a_sense_en_o,
   output logic          v_sense_en_o,
   output logic [1:0]    phase_o
);
   generate
      if (TW < 4 || TW > 24) begin : g_bad_tw
         $error("dcp_sequencer: TW must lie in 4..24");
      end
   endgenerate

   dcp_phase_e    phase;
   logic [TW-1:0] win_len;
   logic          win_last;
   logic          restart;

   dcp_window_sel #(.TW(TW)) u_win (
      .phase_i (phase),
      .lri_i   (lri_i),
      .uri_i   (uri_i),
      .avd_i   (avd_i),
      .len_o   (win_len)
   );

   dcp_interval_timer #(.TW(TW), .DOWN_COUNT(DOWN_COUNT)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .restart_i (restart),
      .len_i     (win_len),
      .last_o    (win_last)
   );

   dcp_phase_ctrl u_ctl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .a_sense_i (a_sense_i),
      .v_sense_i (v_sense_i),
      .last_i    (win_last),
      .phase_o   (phase),
      .a_en_o    (a_sense_en_o),
      .v_en_o    (v_sense_en_o),
      .a_pace_o  (a_pace_o),
      .v_pace_o  (v_pace_o),
      .restart_o (restart)
   );

   assign phase_o = phase;

endmodule

// File: rtl/dcp_sequencer_chk.sv
module dcp_sequencer_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       tick_i,
   input logic       a_pace_o,
   input logic       v_pace_o,
   input logic       a_sense_en_o,
   input logic       v_sense_en_o,
   input logic [1:0] phase_o
);
   // R11
   pace_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(a_pace_o && v_pace_o));

   // R11
   a_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_pace_o |=> !a_pace_o);

   // R11
   v_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_pace_o |=> !v_pace_o);

   // R3
   v_event_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_pace_o |-> (!a_sense_en_o && !v_sense_en_o && phase_o == 2'd1));

   // R7
   a_event_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_pace_o |-> (!a_sense_en_o && v_sense_en_o && phase_o == 2'd3));

   // R4
   a_en_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_sense_en_o |-> (phase_o == 2'd2 && !v_sense_en_o));

   // R10
   idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(phase_o));

   // R2
   pace_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_pace_o || v_pace_o) |-> $past(tick_i));

   // R8
   v_pace_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_pace_o |-> ($past(phase_o) == 2'd0 || $past(phase_o) == 2'd3));

endmodule

bind dcp_sequencer dcp_sequencer_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .tick_i       (tick_i),
   .a_pace_o     (a_pace_o),
   .v_pace_o     (v_pace_o),
   .a_sense_en_o (a_sense_en_o),
   .v_sense_en_o (v_sense_en_o),
   .phase_o      (phase_o)
);

// File: tb/dcp_sequencer_tb.sv
`timescale 1ns/1ps
module dcp_sequencer_tb;
   localparam int TW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          a_s = 1'b0;
   logic          v_s = 1'b0;
   logic [TW-1:0] lri = 12'd20;
   logic [TW-1:0] uri = 12'd5;
   logic [TW-1:0] avd = 12'd4;
   logic          a_pace, v_pace, a_en, v_en;
   logic [1:0]    phase;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference state
   int m_ph, m_rem;
   bit m_fresh, m_aen, m_ven;

   always #2.5 clk = ~clk;

   dcp_sequencer #(.TW(TW)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
      .a_sense_i(a_s), .v_sense_i(v_s),
      .lri_i(lri), .uri_i(uri), .avd_i(avd),
      .a_pace_o(a_pace), .v_pace_o(v_pace),
      .a_sense_en_o(a_en), .v_sense_en_o(v_en),
      .phase_o(phase)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   function automatic int one_min(input int x);
      return (x == 0) ? 1 : x;
   endfunction

   function automatic int win_len(input int ph);
      int d;
      case (ph)
         0: return one_min(int'(lri));
         1: return one_min(int'(uri));
         2: begin
            d = int'(lri) - int'(avd) - int'(uri);
            return (d <= 0) ? 1 : d;
         end
         default: return one_min(int'(avd));
      endcase
   endfunction

   task automatic model_reset();
      m_ph = 0; m_fresh = 1; m_rem = 0; m_aen = 0; m_ven = 1;
   endtask

   task automatic model_tick(input bit a, input bit v, output bit ea, output bit ev, output int prev);
      bit last, ah, vh;
      int nxt;
      prev = m_ph;
      if (m_fresh) begin m_rem = win_len(m_ph); m_fresh = 0; end
      last = (m_rem == 1);
      ah = a && m_aen;
      vh = v && m_ven;
      ea = 0; ev = 0; nxt = m_ph;
      case (m_ph)
         0: if (vh) nxt = 1; else if (last) begin ev = 1; nxt = 1; end
         1: if (last) nxt = 2;
         2: if (ah) nxt = 3; else if (last) begin ea = 1; nxt = 3; end
         default: if (vh) nxt = 1; else if (last) begin ev = 1; nxt = 1; end
      endcase
      if (nxt != m_ph) begin
         m_ph = nxt; m_fresh = 1;
         m_aen = (nxt == 2);
         m_ven = (nxt == 3) || (nxt == 0);
      end else begin
         m_rem--;
      end
   endtask

   task automatic check_state(input string tp, input string te);
      check(tp, "phase", int'(phase), m_ph);
      check(te, "a_sense_en", int'(a_en), int'(m_aen));
      check(te, "v_sense_en", int'(v_en), int'(m_ven));
   endtask

   task automatic do_tick(input bit a, input bit v, input string tag);
      bit ea, ev;
      int prev;
      string tp, te;
      @(negedge clk);
      check("R11", "pace low between ticks", int'(a_pace | v_pace), 0);
      tick = 1; a_s = a; v_s = v;
      model_tick(a, v, ea, ev, prev);
      @(negedge clk);
      tick = 0; a_s = 0; v_s = 0;
      tp = (tag != "") ? tag : (prev == 0 ? "R2" : prev == 1 ? "R3" : prev == 2 ? "R5" : "R8");
      te = (tag != "") ? tag : (m_ph == 1 ? "R3" : m_ph == 2 ? "R4" : "R7");
      check(tp, "a_pace", int'(a_pace), int'(ea));
      check(tp, "v_pace", int'(v_pace), int'(ev));
      check_state(tp, te);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         a_s = 1'($urandom % 2);
         v_s = 1'($urandom % 2);
         @(negedge clk);
         check("R10", "no pace without tick", int'(a_pace | v_pace), 0);
         check_state("R10", "R10");
      end
      a_s = 0; v_s = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "phase", int'(phase), 0);
      check("R1", "v_sense_en", int'(v_en), 1);
      check("R1", "a_sense_en", int'(a_en), 0);
      check("R1", "paces", int'(a_pace | v_pace), 0);

      // R2 first ventricular escape runs out: pace on the 20th tick
      for (int i = 0; i < 20; i++) do_tick(0, 0, "R2");
      check("R2", "v_pace at LRI", int'(v_pace), 1);

      // R3 hold: senses are closed, both ignored (R10)
      for (int i = 0; i < 4; i++) do_tick(1, 1, "R10");
      do_tick(0, 0, "R4");
      check("R4", "phase atrial escape", int'(phase), 2);

      // R10 ventricular sense ignored in atrial escape; R6 early atrial sense
      do_tick(0, 1, "R10");
      do_tick(0, 0, "R6");
      do_tick(1, 0, "R6");
      check("R6", "no a_pace on sense", int'(a_pace), 0);
      check("R7", "phase AV", int'(phase), 3);

      // R8 ventricular sense within AV inhibits pace
      do_tick(1, 0, "R10");
      do_tick(0, 1, "R8");
      check("R8", "phase back to hold", int'(phase), 1);

      // R9 senses coincide with expiries
      for (int i = 0; i < 5; i++) do_tick(0, 0, "R3");
      for (int i = 0; i < 10; i++) do_tick(0, 0, "R5");
      do_tick(1, 0, "R9");
      check("R9", "a_pace on coincident sense", int'(a_pace), 0);
      for (int i = 0; i < 3; i++) do_tick(0, 0, "R8");
      do_tick(0, 1, "R9");
      check("R9", "v_pace on coincident sense", int'(v_pace), 0);

      // R5 full atrial window, R8 full AV delay
      for (int i = 0; i < 5; i++) do_tick(0, 0, "R3");
      for (int i = 0; i < 11; i++) do_tick(0, 0, "R5");
      check("R5", "a_pace at window end", int'(a_pace), 1);
      for (int i = 0; i < 4; i++) do_tick(0, 0, "R8");
      check("R8", "v_pace at AVD", int'(v_pace), 1);

      // R12 / R5 clamp: negative atrial window, zero AV delay
      uri = 12'd10; avd = 12'd15;
      for (int i = 0; i < 10; i++) do_tick(0, 0, "R12");
      do_tick(0, 0, "R5");
      check("R5", "clamped a_pace first tick", int'(a_pace), 1);
      avd = 12'd0;
      do_tick(0, 0, "R12");
      check("R12", "zero AVD paces on first tick", int'(v_pace), 1);

      // R12 mid-window change of the interval inputs has no effect
      uri = 12'd6; lri = 12'd30; avd = 12'd5;
      do_tick(0, 0, "R12");
      uri = 12'd2;
      for (int i = 0; i < 5; i++) do_tick(0, 0, "R12");
      check("R12", "hold used latched URI", int'(phase), 2);

      // random traffic
      for (int k = 0; k < 3000; k++) begin
         if (k % 150 == 0) begin
            lri = 12'(6 + $urandom % 40);
            uri = 12'($urandom % 12);
            avd = 12'($urandom % 14);
         end
         do_tick(1'(($urandom % 7) == 0), 1'(($urandom % 7) == 0), "");
         if (($urandom % 4) == 0) idle(1 + $urandom % 2);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule